// File: doc/BRIEF.md
# PHY Management Register Front End

This block connects a host register port to an on-chip model of a 10/100 Ethernet PHY's management registers. The host programs an address word that selects a PHY address and a register address. It loads a transmit-data word and then issues commands. A write-control command stores the transmit data into the selected PHY register. A read-status command returns the selected register in a read-data register. The model holds sixteen 16-bit registers. Some of them are fixed, one triggers a self-clearing soft reset, and two follow the state of the link. There is no serial management wire protocol in this block.

A command takes effect in the clock cycle after the host writes it. During that cycle `busy` is high, and the results can be seen once it falls. A link-fail flag reports link-down on a read-status command. When the host enables scanning, the flag instead follows the link input continuously.

Top module: `phy_mgmt_front`

## Requirements
- R1: An accepted command write raises `busy` for exactly the next cycle. The command takes effect at the end of that cycle, so read data, PHY writes and link-fail are visible once `busy` is low again.
- R2: The host port selects its target with `hostSel`: 0 is the address word, 1 is transmit data and 2 is the command word. In the address word, bits [12:8] give the register address and bits [4:0] give the PHY address. Only PHY address 1 responds. A read-status command to any other PHY address loads 0xFFFF into the read data.
- R3: A read-status command (command bit 1) loads the selected register into `rdData`. Register addresses 16 and above read as 0x0000. `rdData` does not change except at the end of a busy cycle.
- R4: A read-status command copies the link-down condition (`linkUp` low) into `linkFail`.
- R5: A transmit-data write stores the word. If the PHY address is 1, the same write also stores the word into the selected PHY register at once. For any other PHY address the PHY registers do not change.
- R6: A write-control command (command bit 2) to PHY address 1 writes the stored transmit-data word into the selected register.
- R7: Registers 1, 2 and 3 ignore writes, and so do register addresses of 16 or more. A write to address 20 does not alias onto register 4.
- R8: A write to register 0 with bit 15 set restores every PHY register to its default and stores nothing else.
- R9: The register defaults are: register 0 = 0x1000, register 2 = 0x2000, register 3 = 0x5C90, register 4 = 0x01E1, and all others 0. Register 1 reads 0x7869, with bit 2 added while the link is up.
- R10: When the link goes up, register 5 is ORed with 0x01E1. When the link goes down, register 5 is ANDed with 0x01FF and bit 2 of register 1 is cleared.
- R11: Command bit 0 sets or clears scanning. While scanning is on, `linkFail` takes the inverse of `linkUp` one cycle later. While it is off, link changes leave `linkFail` alone.
- R12: Host writes issued while `busy` is high are dropped. Writes with `hostSel` = 3 have no effect.
- R13: A command with both bit 1 and bit 2 set returns the register contents from before the write and then performs the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWe | input | 1 | Host write strobe |
| hostSel | input | 2 | Host target: 0 address, 1 transmit data, 2 command |
| hostWData | input | 16 | Host write data |
| linkUp | input | 1 | Current link state from the line side |
| busy | output | 1 | High during the command execution cycle |
| rdData | output | 16 | Read-data register |
| linkFail | output | 1 | Link-fail status bit |

## Verification
The assertions check the command timing on every cycle: `busy` lasts one cycle and follows every accepted command, and `rdData` moves only at the end of a busy cycle. They also check that `linkFail` changes only after a read-status command or while scanning, and that while scanning it tracks the link with one cycle of delay. The values inside the register file can only be shown by the bench's scenarios. These include the defaults, the read-only entries, the soft reset, the writes through transmit data versus the command, the masking of register 5 on link changes, the non-responding PHY, and the combined read-then-write command.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int DATA_W = 16;

  // host port targets
  typedef enum logic [1:0] {
    SEL_ADDR   = 2'd0,
    SEL_TXDATA = 2'd1,
    SEL_CMD    = 2'd2,
    SEL_NONE   = 2'd3
  } host_sel_e;

  // command word bits
  localparam int CMD_SCAN_BIT = 0;
  localparam int CMD_RD_BIT   = 1;
  localparam int CMD_WR_BIT   = 2;
  localparam int CMD_W        = 3;

  // address word layout
  localparam int REG_FIELD_LSB = 8;

  // register indices with special behaviour
  localparam int IDX_CTRL    = 0;
  localparam int IDX_STATUS  = 1;
  localparam int IDX_ID_HI   = 2;
  localparam int IDX_ID_LO   = 3;
  localparam int IDX_ADV     = 4;
  localparam int IDX_PARTNER = 5;

  localparam logic [DATA_W-1:0] DEF_CTRL        = 16'h1000;
  localparam logic [DATA_W-1:0] STAT_BASE       = 16'h7869;
  localparam logic [DATA_W-1:0] ID_HI_VAL       = 16'h2000;
  localparam logic [DATA_W-1:0] ID_LO_VAL       = 16'h5C90;
  localparam logic [DATA_W-1:0] DEF_ADV         = 16'h01E1;
  localparam logic [DATA_W-1:0] PARTNER_UP_BITS = 16'h01E1;
  localparam logic [DATA_W-1:0] PARTNER_DN_MASK = 16'h01FF;
  localparam int STAT_LINK_BIT = 2;
  localparam int CTRL_RST_BIT  = 15;

  // strobes from control to datapath
  typedef struct packed {
    logic addrLoad;
    logic txLoad;
    logic scanLoad;
    logic scanVal;
    logic doRead;
    logic doWrite;
  } mgmt_strobe_t;
endpackage

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
  import phy_mgmt_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      hostWe,
  input  logic [1:0]                hostSel,
  input  logic [CMD_W-1:0]          cmdBits,
  output logic                      busy,
  output mgmt_strobe_t              strobe
);
  logic accept;
  logic cmdAccept;
  logic pendRd;
  logic pendWr;

  // writes arriving during the execution cycle are dropped
  assign accept    = hostWe && !busy;
  assign cmdAccept = accept && (hostSel == SEL_CMD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      pendRd <= 1'b0;
      pendWr <= 1'b0;
    end else begin
      busy   <= cmdAccept;
      pendRd <= cmdAccept && cmdBits[CMD_RD_BIT];
      pendWr <= cmdAccept && cmdBits[CMD_WR_BIT];
    end
  end

  always_comb begin
    strobe.addrLoad = accept && (hostSel == SEL_ADDR);
    strobe.txLoad   = accept && (hostSel == SEL_TXDATA);
    strobe.scanLoad = cmdAccept;
    strobe.scanVal  = cmdBits[CMD_SCAN_BIT];
    strobe.doRead   = busy && pendRd;
    strobe.doWrite  = busy && pendWr;
  end
endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
  import phy_mgmt_pkg::*;
#(
  parameter int PHY_AW   = 5,
  parameter int REG_AW   = 5,
  parameter int NUM_REGS = 16,
  parameter int RESP_PHY = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  mgmt_strobe_t      strobe,
  input  logic [DATA_W-1:0] hostWData,
  input  logic              linkUp,
  output logic [DATA_W-1:0] rdData,
  output logic              linkFail,
  output logic              scanOn
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [PHY_AW-1:0] phyAddrQ;
  logic [REG_AW-1:0] regAddrQ;
  logic [DATA_W-1:0] txDataQ;
  logic              linkQ;
  logic [DATA_W-1:0] store [NUM_REGS];

  logic              phyHit;
  logic              inRange;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] wrData;
  logic              phyWe;
  logic              softRst;
  logic              linkRise;
  logic              linkFall;
  logic [DATA_W-1:0] rdVal;

  assign phyHit   = (phyAddrQ == PHY_AW'(RESP_PHY));
  assign inRange  = (regAddrQ < REG_AW'(NUM_REGS));
  assign idx      = regAddrQ[IDX_W-1:0];
  assign wrData   = strobe.txLoad ? hostWData : txDataQ;
  assign phyWe    = phyHit && inRange && (strobe.txLoad || strobe.doWrite);
  assign softRst  = phyWe && (idx == IDX_W'(IDX_CTRL)) && wrData[CTRL_RST_BIT];
  assign linkRise = linkUp && !linkQ;
  assign linkFall = !linkUp && linkQ;
  assign rdVal    = inRange ? store[idx] : '0;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [DATA_W-1:0] DEF_VAL =
      (i == IDX_CTRL) ? DEF_CTRL : (i == IDX_ADV) ? DEF_ADV : '0;
    if (i == IDX_STATUS) begin : g_status
      assign store[i] = STAT_BASE | (DATA_W'(linkQ) << STAT_LINK_BIT);
    end else if (i == IDX_ID_HI || i == IDX_ID_LO) begin : g_ident
      assign store[i] = (i == IDX_ID_HI) ? ID_HI_VAL : ID_LO_VAL;
    end else begin : g_rw
      logic [DATA_W-1:0] nxt;
      always_comb begin
        nxt = store[i];
        if (phyWe && (idx == IDX_W'(i))) nxt = wrData;
        if (i == IDX_PARTNER) begin
          if (linkRise) nxt = nxt | PARTNER_UP_BITS;
          if (linkFall) nxt = nxt & PARTNER_DN_MASK;
        end
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          store[i] <= DEF_VAL;
        else if (softRst)
          store[i] <= (i == IDX_PARTNER && linkUp) ? PARTNER_UP_BITS : DEF_VAL;
        else
          store[i] <= nxt;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phyAddrQ <= '0;
      regAddrQ <= '0;
      txDataQ  <= '0;
      rdData   <= '0;
      linkFail <= 1'b0;
      scanOn   <= 1'b0;
      linkQ    <= 1'b0;
    end else begin
      linkQ <= linkUp;
      if (strobe.addrLoad) begin
        regAddrQ <= hostWData[REG_FIELD_LSB +: REG_AW];
        phyAddrQ <= hostWData[0 +: PHY_AW];
      end
      if (strobe.txLoad) txDataQ <= hostWData;
      if (strobe.scanLoad) scanOn <= strobe.scanVal;
      if (strobe.doRead) rdData <= phyHit ? rdVal : '1;
      if (strobe.doRead || scanOn) linkFail <= !linkUp;
    end
  end
endmodule

// File: rtl/phy_mgmt_front.sv
module phy_mgmt_front
  import phy_mgmt_pkg::*;
#(
  parameter int PHY_AW   = 5,
  parameter int REG_AW   = 5,
  parameter int NUM_REGS = 16,
  parameter int RESP_PHY = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic [1:0]        hostSel,
  input  logic [DATA_W-1:0] hostWData,
  input  logic              linkUp,
  output logic              busy,
  output logic [DATA_W-1:0] rdData,
  output logic              linkFail
);
  mgmt_strobe_t strobe;
  logic         scanOn;

  phy_mgmt_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .hostWe  (hostWe),
    .hostSel (hostSel),
    .cmdBits (hostWData[CMD_W-1:0]),
    .busy    (busy),
    .strobe  (strobe)
  );

  phy_mgmt_regfile #(
    .PHY_AW   (PHY_AW),
    .REG_AW   (REG_AW),
    .NUM_REGS (NUM_REGS),
    .RESP_PHY (RESP_PHY)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .hostWData (hostWData),
    .linkUp    (linkUp),
    .rdData    (rdData),
    .linkFail  (linkFail),
    .scanOn    (scanOn)
  );
endmodule

// File: rtl/phy_mgmt_front_chk.sv
module phy_mgmt_front_chk (
  input logic        clk,
  input logic        rstN,
  input logic        hostWe,
  input logic [1:0]  hostSel,
  input logic        busy,
  input logic [15:0] rdData,
  input logic        linkFail,
  input logic        linkUp,
  input logic        scanOn
);
  // R1
  busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);

  // R1
  cmd_raises_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWe && hostSel == 2'd2 && !busy) |=> busy);

  // R1
  busy_only_from_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !(hostWe && hostSel == 2'd2)) |=> !busy);

  // R3
  rddata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(rdData));

  // R4
  linkfail_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $changed(linkFail) |-> ($past(busy) || $past(scanOn)));

  // R11
  scan_tracks_link_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(scanOn) |-> (linkFail == !$past(linkUp)));
endmodule

bind phy_mgmt_front phy_mgmt_front_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .hostWe   (hostWe),
  .hostSel  (hostSel),
  .busy     (busy),
  .rdData   (rdData),
  .linkFail (linkFail),
  .linkUp   (linkUp),
  .scanOn   (scanOn)
);

// File: tb/tb_phy_mgmt_front.sv
`timescale 1ns/1ps
module tb_phy_mgmt_front;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWe = 1'b0;
  logic [1:0]  hostSel = 2'd0;
  logic [15:0] hostWData = 16'h0;
  logic        linkUp = 1'b1;
  logic        busy;
  logic [15:0] rdData;
  logic        linkFail;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [17:0] expQ[$];   // {checkIt, expLinkFail, expData}
  string       reqQ[$];
  logic        prevBusy = 1'b0;

  always #4 clk = ~clk;

  phy_mgmt_front dut (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostSel(hostSel),
    .hostWData(hostWData), .linkUp(linkUp), .busy(busy),
    .rdData(rdData), .linkFail(linkFail)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: a command result is ready when busy falls
  initial begin
    forever begin
      @(negedge clk);
      if (prevBusy && !busy) begin
        if (expQ.size() == 0) begin
          check("R1 unexpected completion", 16'h1, 16'h0);
        end else begin
          logic [17:0] item;
          string r;
          item = expQ.pop_front();
          r = reqQ.pop_front();
          if (item[17]) begin
            check(r, rdData, item[15:0]);
            check({r, " linkFail"}, {15'h0, linkFail}, {15'h0, item[16]});
          end
        end
      end
      prevBusy = busy;
    end
  end

  task automatic hostWrite(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    hostWe = 1'b1; hostSel = sel; hostWData = d;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic setAddr(input logic [4:0] phy, input logic [4:0] rg);
    hostWrite(2'd0, {3'b0, rg, 3'b0, phy});
  endtask

  task automatic txWrite(input logic [15:0] d);
    hostWrite(2'd1, d);
  endtask

  task automatic issueCmd(input logic [2:0] bits, input logic chk,
                          input logic [15:0] exp, input logic lf, input string req);
    expQ.push_back({chk, lf, exp});
    reqQ.push_back(req);
    hostWrite(2'd2, {13'h0, bits});
    @(negedge clk);
  endtask

  task automatic readReg(input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] exp, input logic lf, input string req);
    setAddr(phy, rg);
    issueCmd(3'b010, 1'b1, exp, lf, req);
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset busy", {15'h0, busy}, 16'h0);
    check("R9 reset rdData", rdData, 16'h0);
    check("R9 reset linkFail", {15'h0, linkFail}, 16'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R9 defaults, R10 link-up bits
    readReg(1, 0, 16'h1000, 1'b0, "R9 reg0");
    readReg(1, 1, 16'h786D, 1'b0, "R10 reg1 link up");
    readReg(1, 2, 16'h2000, 1'b0, "R9 reg2");
    readReg(1, 3, 16'h5C90, 1'b0, "R9 reg3");
    readReg(1, 4, 16'h01E1, 1'b0, "R9 reg4");
    readReg(1, 5, 16'h01E1, 1'b0, "R10 reg5 link up");
    readReg(1, 20, 16'h0000, 1'b0, "R3 out of range read");
    readReg(3, 0, 16'hFFFF, 1'b0, "R2 other phy");
    readReg(0, 4, 16'hFFFF, 1'b0, "R2 phy zero");

    // R1 busy timing and result visibility
    setAddr(1, 0);
    expQ.push_back({1'b1, 1'b0, 16'h1000});
    reqQ.push_back("R1 read result");
    hostWrite(2'd2, 16'h0002);
    check("R1 busy high", {15'h0, busy}, 16'h1);
    @(negedge clk);
    check("R1 busy low", {15'h0, busy}, 16'h0);
    check("R1 data valid", rdData, 16'h1000);

    // R5 immediate write via transmit data
    setAddr(1, 4); txWrite(16'h0061);
    readReg(1, 4, 16'h0061, 1'b0, "R5 immediate write");

    // R7 read-only and out-of-range writes
    setAddr(1, 2); txWrite(16'hFFFF);
    readReg(1, 2, 16'h2000, 1'b0, "R7 reg2 read-only");
    setAddr(1, 1); txWrite(16'h0000);
    readReg(1, 1, 16'h786D, 1'b0, "R7 reg1 read-only");
    setAddr(1, 20); txWrite(16'hAAAA);
    readReg(1, 4, 16'h0061, 1'b0, "R7 no alias from 20");

    // R5 other phy does not write, R6 write-control
    setAddr(2, 7); txWrite(16'h1234);
    readReg(1, 7, 16'h0000, 1'b0, "R5 phy2 no write");
    issueCmd(3'b100, 1'b0, 16'h0, 1'b0, "R6 write cmd");
    readReg(1, 7, 16'h1234, 1'b0, "R6 write-control");

    // R13 combined read and write
    setAddr(2, 8); txWrite(16'h5555);
    setAddr(1, 8);
    issueCmd(3'b110, 1'b1, 16'h0000, 1'b0, "R13 read before write");
    readReg(1, 8, 16'h5555, 1'b0, "R13 write done");

    // R8 soft reset
    setAddr(1, 0); txWrite(16'h0100);
    readReg(1, 0, 16'h0100, 1'b0, "R5 reg0 plain write");
    setAddr(1, 0); txWrite(16'h8000);
    readReg(1, 0, 16'h1000, 1'b0, "R8 reg0 restored");
    readReg(1, 4, 16'h01E1, 1'b0, "R8 reg4 restored");
    readReg(1, 7, 16'h0000, 1'b0, "R8 reg7 cleared");
    readReg(1, 5, 16'h01E1, 1'b0, "R8 reg5 with link");

    // R10 link down/up, R4 link-fail on read
    setAddr(1, 5); txWrite(16'hFFFF);
    @(negedge clk); linkUp = 1'b0;
    repeat (2) @(negedge clk);
    readReg(1, 5, 16'h01FF, 1'b1, "R10 reg5 masked R4");
    readReg(1, 1, 16'h7869, 1'b1, "R10 reg1 link down");
    setAddr(1, 5); txWrite(16'h0002);
    @(negedge clk); linkUp = 1'b1;
    repeat (2) @(negedge clk);
    readReg(1, 5, 16'h01E3, 1'b0, "R10 reg5 ored R4");

    // R11 scanning
    issueCmd(3'b001, 1'b0, 16'h0, 1'b0, "R11 scan on");
    linkUp = 1'b0;
    @(negedge clk);
    check("R11 scan follows down", {15'h0, linkFail}, 16'h1);
    linkUp = 1'b1;
    @(negedge clk);
    check("R11 scan follows up", {15'h0, linkFail}, 16'h0);
    issueCmd(3'b000, 1'b0, 16'h0, 1'b0, "R11 scan off");
    linkUp = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 no scan no change", {15'h0, linkFail}, 16'h0);
    linkUp = 1'b1;
    repeat (2) @(negedge clk);

    // R12 writes during busy dropped, sel 3 ignored
    setAddr(1, 0);
    expQ.push_back({1'b1, 1'b0, 16'h1000});
    reqQ.push_back("R12 read under drop");
    @(negedge clk);
    hostWe = 1'b1; hostSel = 2'd2; hostWData = 16'h0002;
    @(negedge clk);
    hostSel = 2'd0; hostWData = {3'b0, 5'd4, 3'b0, 5'd3};
    @(negedge clk);
    hostWe = 1'b0;
    issueCmd(3'b010, 1'b1, 16'h1000, 1'b0, "R12 address kept");
    hostWrite(2'd3, 16'h0003);
    issueCmd(3'b010, 1'b1, 16'h1000, 1'b0, "R12 sel3 ignored");

    repeat (4) @(negedge clk);
    check("R1 all results seen", 16'(expQ.size()), 16'h0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule